// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This control block sits beside the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register numbers of the instruction in decode. It compares them against the destinations of the two older instructions, the one now in execute and the one now in memory. From that comparison it works out where each ALU operand must come from once the decoded instruction reaches execute. The answer is registered on the same edge that advances the instruction, so the operand mux selects are valid for the whole execute cycle. Each operand has four possible sources: the register-file value, the ALU result held after execute, the ALU result held after memory, and the load data held after memory.

A load whose result is needed by the very next instruction cannot be covered by any bypass path. The block detects this in decode and raises a hold for the PC and the fetch/decode register. In the same cycle it tells the pipeline to put a bubble into the decode/execute register. On the next cycle the waiting instruction is evaluated again and takes the load data from the memory/writeback register. There is one exception. When the dependent instruction is a store that needs the loaded value only as its store data, there is no stall. Instead a flag is raised two cycles later, during the store's memory stage, so that the memory write data is taken from the loaded value.

Top module: `fwd_interlock_unit`

## Requirements
- R1: Operand select encoding is 2'b00 register file, 2'b01 ALU result held after execute, 2'b10 ALU result held after memory, 2'b11 load data held after memory. The selects for the instruction in decode appear on `opa_sel`/`opb_sel` one clock edge later, that is, while the instruction is in execute.
- R2: A source equal to `ex_rd`, with `ex_wen` high and `ex_is_load` low, selects 2'b01.
- R3: A source equal to `mem_rd`, with `mem_wen` high and `mem_is_load` low, selects 2'b10, unless R2 applies.
- R4: A source equal to `mem_rd`, with `mem_wen` high and `mem_is_load` high, selects 2'b11, unless R2 applies.
- R5: When both older instructions write the same source register, the one in execute (the younger) wins.
- R6: A destination of register 0 is never forwarded: a source of 0 always selects 2'b00.
- R7: A destination whose write enable is low is never forwarded.
- R8: A load in execute whose destination (nonzero, write enabled) equals `id_rs1`, or equals `id_rs2` of a non-store, raises `pc_hold`, `ifid_hold` and `idex_bubble` in the same cycle, combinationally.
- R9: On an edge where a stall is raised, both registered selects become 2'b00 and no store-data forward is scheduled for the bubble.
- R10: Exactly one bubble is inserted. Once the load has moved to memory, the held instruction gets no stall and selects 2'b11.
- R11: A store whose `id_rs2` alone matches a load in execute does not stall. `store_fwd` is high for exactly the cycle after the second following edge, while that store is in memory.
- R12: While `rst` is high, both selects are 2'b00 and `store_fwd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_AW | First source register of the instruction in decode |
| id_rs2 | input | REG_AW | Second source register of the instruction in decode |
| id_is_store | input | 1 | Instruction in decode is a store (rs2 is store data) |
| ex_rd | input | REG_AW | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mem_is_load | input | 1 | Instruction in memory is a load |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a bubble into decode/execute this cycle |
| opa_sel | output | 2 | Registered source select for ALU operand A |
| opb_sel | output | 2 | Registered source select for ALU operand B |
| store_fwd | output | 1 | Store in memory takes its write data from the loaded value |

## Verification
A wrong comparison or a wrong priority shows up as an incorrect select code on the cycle right after the dependent instruction leaves decode. Nothing hides it, because the selects are only one register deep. A faulty interlock shows up combinationally: either a hold is missing in the same cycle as the load-use pair, or a store is stalled when it should not be. The missing bubble, or the missing recovery to load-data selection, then appears one edge later. A corrupted store-data flag shows up two edges after the store was decoded.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF      = 2'b00,
    SRC_EXM_ALU = 2'b01,
    SRC_MWB_ALU = 2'b10,
    SRC_MWB_LD  = 2'b11
  } fwd_src_e;
endpackage

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  output fwd_src_e          pick,
  output logic              ex_load_hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic ex_match, mem_match;

  // a destination of register 0 or with write disabled never matches
  assign ex_match  = ex_wen  && (ex_rd  != ZERO_REG) && (ex_rd  == src);
  assign mem_match = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign ex_load_hit = ex_match && ex_is_load;

  always_comb begin
    if (ex_match) begin
      // younger producer wins; a load there is handled by the interlock
      pick = ex_is_load ? SRC_RF : SRC_EXM_ALU;
    end else if (mem_match) begin
      pick = mem_is_load ? SRC_MWB_LD : SRC_MWB_ALU;
    end else begin
      pick = SRC_RF;
    end
  end
endmodule

// File: rtl/fwd_hazard_detect.sv
module fwd_hazard_detect (
  input  logic a_load_hit,
  input  logic b_load_hit,
  input  logic is_store,
  output logic stall,
  output logic store_path
);
  // store data is needed only in memory, so rs2 of a store can wait
  assign stall      = a_load_hit || (b_load_hit && !is_store);
  assign store_path = b_load_hit && is_store && !stall;
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_is_store,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic [1:0]        opa_sel,
  output logic [1:0]        opb_sel,
  output logic              store_fwd
);
  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] src_num  [NUM_OPS];
  fwd_src_e          pick     [NUM_OPS];
  logic              ld_hit   [NUM_OPS];
  fwd_src_e          sel_q    [NUM_OPS];
  logic              stall;
  logic              store_path;
  logic              st_ex_q, st_mem_q;

  assign src_num[0] = id_rs1;
  assign src_num[1] = id_rs2;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_src_pick #(.REG_AW(REG_AW)) u_pick (
      .src         (src_num[g]),
      .ex_rd       (ex_rd),
      .ex_wen      (ex_wen),
      .ex_is_load  (ex_is_load),
      .mem_rd      (mem_rd),
      .mem_wen     (mem_wen),
      .mem_is_load (mem_is_load),
      .pick        (pick[g]),
      .ex_load_hit (ld_hit[g])
    );

    always_ff @(posedge clk) begin
      if (rst || stall) sel_q[g] <= SRC_RF;
      else              sel_q[g] <= pick[g];
    end
  end

  fwd_hazard_detect u_hz (
    .a_load_hit (ld_hit[0]),
    .b_load_hit (ld_hit[1]),
    .is_store   (id_is_store),
    .stall      (stall),
    .store_path (store_path)
  );

  // store-data flag travels with the store through execute into memory
  always_ff @(posedge clk) begin
    if (rst) begin
      st_ex_q  <= 1'b0;
      st_mem_q <= 1'b0;
    end else begin
      st_ex_q  <= store_path;
      st_mem_q <= st_ex_q;
    end
  end

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign opa_sel     = sel_q[0];
  assign opb_sel     = sel_q[1];
  assign store_fwd   = st_mem_q;
endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              ex_wen,
  input logic              ex_is_load,
  input logic              mem_is_load,
  input logic              pc_hold,
  input logic [1:0]        opa_sel,
  input logic [1:0]        opb_sel,
  input logic              store_fwd
);
  // R8: a hold needs a load in execute
  a_r8_hold_needs_load: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> (ex_wen && ex_is_load));

  // R9: a stall edge leaves both selects on the register file
  a_r9_bubble_sel: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> (opa_sel == 2'b00 && opb_sel == 2'b00));

  // R9: no store-data forward for a bubble
  a_r9_bubble_store: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> ##1 !store_fwd);

  // R6: sources of register 0 are never bypassed
  a_r6_zero_src: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0 && id_rs2 == '0 && !pc_hold) |=> (opa_sel == 2'b00 && opb_sel == 2'b00));

  // R4: load-data select only when memory held a load
  a_r4_load_sel: assert property (@(posedge clk) disable iff (rst)
    (!mem_is_load) |=> (opa_sel != 2'b11 && opb_sel != 2'b11));

  // R2: select from execute only when execute wrote a non-load
  a_r2_ex_sel: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen || ex_is_load) |=> (opa_sel != 2'b01 && opb_sel != 2'b01));
endmodule

bind fwd_interlock_unit fwd_interlock_chk #(.REG_AW(REG_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .id_rs1      (id_rs1),
  .id_rs2      (id_rs2),
  .ex_wen      (ex_wen),
  .ex_is_load  (ex_is_load),
  .mem_is_load (mem_is_load),
  .pc_hold     (pc_hold),
  .opa_sel     (opa_sel),
  .opb_sel     (opb_sel),
  .store_fwd   (store_fwd)
);

// File: tb/fwd_interlock_unit_test.sv
`timescale 1ns/1ps
module fwd_interlock_unit_test;
  localparam int AW = 5;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic id_is_store = 1'b0, ex_wen = 1'b0, ex_is_load = 1'b0;
  logic mem_wen = 1'b0, mem_is_load = 1'b0;
  logic pc_hold, ifid_hold, idex_bubble, store_fwd;
  logic [1:0] opa_sel, opb_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fwd_interlock_unit #(.REG_AW(AW)) uut (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_store(id_is_store),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .store_fwd(store_fwd)
  );

  // rs1, rs2, store, ex_rd, ex_wen, ex_ld, mem_rd, mem_wen, mem_ld, stall, a, b
  localparam logic [29:0] VEC [NV] = '{
    {5'd1, 5'd2, 1'b0, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00}, // no hazard
    {5'd1, 5'd2, 1'b0, 5'd1, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 2'b01, 2'b00}, // R2
    {5'd1, 5'd2, 1'b0, 5'd3, 1'b1, 1'b0, 5'd2, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10}, // R3
    {5'd1, 5'd2, 1'b0, 5'd3, 1'b1, 1'b0, 5'd1, 1'b1, 1'b1, 1'b0, 2'b11, 2'b00}, // R4
    {5'd1, 5'd2, 1'b0, 5'd1, 1'b1, 1'b0, 5'd1, 1'b1, 1'b1, 1'b0, 2'b01, 2'b00}, // R5
    {5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00}, // R6
    {5'd1, 5'd2, 1'b0, 5'd1, 1'b0, 1'b0, 5'd2, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00}, // R7
    {5'd1, 5'd7, 1'b0, 5'd7, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}, // R8 rs2
    {5'd7, 5'd2, 1'b1, 5'd7, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}, // R8 store rs1
    {5'd1, 5'd7, 1'b1, 5'd7, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00}, // R11 no stall
    {5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 2'b01, 2'b01}, // R2 both
    {5'd0, 5'd3, 1'b0, 5'd0, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00}, // R6 load r0
    {5'd1, 5'd2, 1'b0, 5'd1, 1'b1, 1'b0, 5'd2, 1'b1, 1'b1, 1'b0, 2'b01, 2'b11}  // R2 + R4
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [29:0] v);
    {id_rs1, id_rs2, id_is_store, ex_rd, ex_wen, ex_is_load, mem_rd, mem_wen, mem_is_load} = v[29:5];
  endtask

  task automatic idle();
    drive({5'd1, 5'd2, 1'b0, 5'd3, 1'b0, 1'b0, 5'd4, 1'b0, 1'b0, 5'd0});
  endtask

  initial begin
    // R12: hazard present on the inputs while reset is held
    drive(VEC[1]);
    repeat (2) @(posedge clk);
    #1;
    chk("R12 opa_sel in reset", opa_sel, 0);
    chk("R12 store_fwd in reset", store_fwd, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      chk($sformatf("R8 stall vec%0d", i), pc_hold, VEC[i][4]);
      chk($sformatf("R8 holds agree vec%0d", i), {ifid_hold, idex_bubble}, {2{VEC[i][4]}});
      @(posedge clk);
      #1;
      chk($sformatf("R1 opa_sel vec%0d", i), opa_sel, VEC[i][3:2]);
      chk($sformatf("R1 opb_sel vec%0d", i), opb_sel, VEC[i][1:0]);
    end

    // R10: load-use, then the load moves to memory
    @(negedge clk);
    idle();
    @(negedge clk);
    drive({5'd1, 5'd7, 1'b0, 5'd7, 1'b1, 1'b1, 5'd4, 1'b0, 1'b0, 5'd0});
    #1 chk("R8 load-use stall", pc_hold, 1);
    @(posedge clk);
    #1 chk("R9 bubble opb_sel", opb_sel, 0);
    @(negedge clk);
    drive({5'd1, 5'd7, 1'b0, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 1'b1, 5'd0});
    #1 chk("R10 no second stall", pc_hold, 0);
    @(posedge clk);
    #1 chk("R10 load data select", opb_sel, 3);

    // R11: load then store of the loaded register
    @(negedge clk);
    drive({5'd1, 5'd6, 1'b1, 5'd6, 1'b1, 1'b1, 5'd4, 1'b0, 1'b0, 5'd0});
    #1 chk("R11 store not stalled", pc_hold, 0);
    @(posedge clk);
    #1 chk("R11 store_fwd early", store_fwd, 0);
    @(negedge clk);
    idle();
    @(posedge clk);
    #1 chk("R11 store_fwd in memory", store_fwd, 1);
    @(posedge clk);
    #1 chk("R11 store_fwd one cycle", store_fwd, 0);

    // R9: a stalled store schedules no store-data forward
    @(negedge clk);
    drive({5'd6, 5'd6, 1'b1, 5'd6, 1'b1, 1'b1, 5'd4, 1'b0, 1'b0, 5'd0});
    #1 chk("R8 store address stall", pc_hold, 1);
    @(posedge clk);
    @(negedge clk);
    idle();
    @(posedge clk);
    #1 chk("R9 no store_fwd for bubble", store_fwd, 0);

    // R7: load in execute with write disabled does not stall
    @(negedge clk);
    drive({5'd7, 5'd2, 1'b0, 5'd7, 1'b0, 1'b1, 5'd4, 1'b0, 1'b0, 5'd0});
    #1 chk("R7 disabled load no stall", pc_hold, 0);

    // R12: reset clears a live select
    @(negedge clk);
    drive(VEC[1]);
    @(posedge clk);
    #1 chk("R2 before reset", opa_sel, 1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 chk("R12 reset clears select", opa_sel, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule